// File: doc/BRIEF.md
# 4x4 Dequantizing Inverse Transform with Reconstruction

This block turns one 4x4 block of quantized transform coefficients back into sixteen 8-bit pixels. A block arrives as sixteen signed 16-bit coefficients, sixteen 16-bit scale factors and sixteen unsigned predictor pixels, all presented together under a valid/ready handshake. The block scales each coefficient by its factor and runs a separable integer inverse transform. The first pass works down each column and the second pass works along each row. It then rounds the residual, adds it to the predictor and clamps the result to the pixel range.

The datapath is iterative. It uses four lanes and handles one column per cycle during the first pass, then one row per cycle during the second. The intermediate block sits in a small register array, and the transpose between the passes is done by how that array is addressed. The cycle after a block is taken, a one-cycle pulse tells the coefficient store that it may zero the sixteen coefficients it just handed over. The finished pixels stay on the output until they are accepted. Only after that does the block take new input.

Top module: `idct4_recon`

## Requirements
- R1: Each coefficient is multiplied by the scale factor with the same index, and only the low 16 bits of the product are kept and read as a signed value (wraparound, no saturation). Element i of `in_coef`, `in_dqf`, `in_pred` and `out_pix` sits at bits [W*i +: W], with i = row*4 + column.
- R2: The odd-part terms are s(x) = (x*35468)>>16 and k(x) = sat(x + ((x*20091)>>16)), with arithmetic shifts on a signed 16-bit x.
- R3: A 1-D pass over x0..x3 forms e0 = x0+x2, e1 = x0-x2, o1 = s(x1)-k(x3), o0 = k(x1)+s(x3), and outputs y0 = e0+o0, y1 = e1+o1, y2 = e1-o1, y3 = e0-o0. Every addition and subtraction saturates to -32768..32767.
- R4: The first pass runs on each column, with x0..x3 taken from rows 0..3 and y0..y3 written back to rows 0..3. The second pass runs on each row of that result, with x and y indexed by column.
- R5: Only after the second pass, each value v becomes (v+4)>>3 using an arithmetic shift. The first-pass results are not rounded.
- R6: Each output pixel equals the predictor pixel at the same index plus the rounded residual, clamped to 0..255.
- R7: `in_ready` is high only when the block is idle and holds no unaccepted result. While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_pix` stays unchanged, and `in_valid` is ignored.
- R8: `coef_clear` goes high for exactly one cycle, in the cycle right after each accepted block, and at no other time.
- R9: `out_valid` rises after the 8th rising clock edge that follows the edge at which the block was accepted.
- R10: Synchronous active-high `rst` drives `out_valid` and `coef_clear` low and `in_ready` high on the next edge, and drops any block in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can take a new input |
| in_coef | input | 256 | Sixteen signed quantized coefficients, raster order |
| in_dqf | input | 256 | Sixteen 16-bit scale factors, raster order |
| in_pred | input | 128 | Sixteen unsigned 8-bit predictor pixels, raster order |
| out_valid | output | 1 | Reconstructed block present |
| out_ready | input | 1 | Downstream takes the output block |
| out_pix | output | 128 | Sixteen reconstructed 8-bit pixels, raster order |
| coef_clear | output | 1 | One-cycle request to zero the consumed coefficients |

## Verification
The bench targets the rounding boundaries around (v+4)>>3 for small positive and negative values. A design that truncated, or that rounded away from zero, would be one level off on these. A product whose low 16 bits read as negative checks that the scaling wraps instead of saturating, since a saturating multiplier would produce white where black is expected. Blocks with a single nonzero coefficient at each of the sixteen positions expose a missing or reversed transpose, because the energy would land on the wrong axis. Full-scale coefficients drive the k(x) term and the butterflies into saturation, so an adder that wraps would flip pixels between 0 and 255. Output stalls, with new input offered during the stall, show whether a design overwrites or drops the held result.

// File: rtl/idct4_pkg.sv
package idct4_pkg;

   localparam int unsigned CW     = 16;
   localparam int unsigned K_SIN  = 35468;
   localparam int unsigned K_COS  = 20091;

   typedef logic signed [CW-1:0] coef_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_COL  = 2'd1,
      PH_ROW  = 2'd2,
      PH_HOLD = 2'd3
   } phase_t;

   function automatic coef_t clip17(input logic signed [CW:0] s);
      if (s[CW] != s[CW-1])
         return s[CW] ? {1'b1, {(CW-1){1'b0}}} : {1'b0, {(CW-1){1'b1}}};
      return s[CW-1:0];
   endfunction

   function automatic coef_t sat_add(input coef_t a, input coef_t b);
      logic signed [CW:0] s;
      s = {a[CW-1], a} + {b[CW-1], b};
      return clip17(s);
   endfunction

   function automatic coef_t sat_sub(input coef_t a, input coef_t b);
      logic signed [CW:0] s;
      s = {a[CW-1], a} - {b[CW-1], b};
      return clip17(s);
   endfunction

   // upper half of x*k for an unsigned constant k below 2^CW
   function automatic coef_t mul_hi(input coef_t x, input int unsigned k);
      logic signed [2*CW+1:0] p;
      p = $signed({{(CW+2){x[CW-1]}}, x}) * $signed((2*CW+2)'(k));
      return p[2*CW-1:CW];
   endfunction

   function automatic coef_t s_term(input coef_t x);
      return mul_hi(x, K_SIN);
   endfunction

   function automatic coef_t k_term(input coef_t x);
      return sat_add(x, mul_hi(x, K_COS));
   endfunction

endpackage

// File: rtl/idct4_dequant.sv
module idct4_dequant
   import idct4_pkg::*;
(
   input  coef_t             coef_i,
   input  logic [CW-1:0]     fac_i,
   output coef_t             deq_o
);
   // low half of the product only: wraps, never saturates
   assign deq_o = coef_i * coef_t'(fac_i);
endmodule

// File: rtl/idct4_bfly.sv
module idct4_bfly
   import idct4_pkg::*;
(
   input  coef_t x0_i,
   input  coef_t x1_i,
   input  coef_t x2_i,
   input  coef_t x3_i,
   output coef_t y0_o,
   output coef_t y1_o,
   output coef_t y2_o,
   output coef_t y3_o
);
   coef_t ev0, ev1, od0, od1;

   always_comb begin
      ev0 = sat_add(x0_i, x2_i);
      ev1 = sat_sub(x0_i, x2_i);
      od1 = sat_sub(s_term(x1_i), k_term(x3_i));
      od0 = sat_add(k_term(x1_i), s_term(x3_i));
   end

   assign y0_o = sat_add(ev0, od0);
   assign y1_o = sat_add(ev1, od1);
   assign y2_o = sat_sub(ev1, od1);
   assign y3_o = sat_sub(ev0, od0);
endmodule

// File: rtl/idct4_px.sv
module idct4_px
   import idct4_pkg::*;
#(
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned ROUND_SH = 3
) (
   input  coef_t              v_i,
   input  logic [PIX_W-1:0]   pred_i,
   output logic [PIX_W-1:0]   pix_o
);
   localparam logic signed [CW:0] RND  = (CW+1)'(1 << (ROUND_SH-1));
   localparam logic signed [CW:0] PMAX = (CW+1)'((1 << PIX_W) - 1);

   if (ROUND_SH < 1 || ROUND_SH >= CW) begin : g_bad_sh
      $error("idct4_px: ROUND_SH out of range");
   end
   if (PIX_W >= CW) begin : g_bad_pw
      $error("idct4_px: PIX_W must be narrower than the coefficient");
   end

   logic signed [CW:0] biased, res, total;

   always_comb begin
      biased = {v_i[CW-1], v_i} + RND;
      res    = biased >>> ROUND_SH;
      total  = res + $signed({{(CW+1-PIX_W){1'b0}}, pred_i});
      if (total < 0)
         pix_o = '0;
      else if (total > PMAX)
         pix_o = {PIX_W{1'b1}};
      else
         pix_o = total[PIX_W-1:0];
   end
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
   import idct4_pkg::*;
#(
   parameter int unsigned COEF_W   = 16,
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned ROUND_SH = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [16*COEF_W-1:0]  in_coef,
   input  logic [16*COEF_W-1:0]  in_dqf,
   input  logic [16*PIX_W-1:0]   in_pred,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [16*PIX_W-1:0]   out_pix,
   output logic                  coef_clear
);
   localparam int unsigned NPT = 4;
   localparam int unsigned NEL = NPT * NPT;
   localparam int unsigned SW  = $clog2(NPT);

   if (COEF_W != CW) begin : g_bad_cw
      $error("idct4_recon: COEF_W must match the package width");
   end

   coef_t             coef_q [NEL];
   logic [CW-1:0]     dqf_q  [NEL];
   logic [PIX_W-1:0]  pred_q [NEL];
   coef_t             mid_q  [NEL];
   logic [PIX_W-1:0]  pix_q  [NEL];
   phase_t            ph_q;
   logic [SW-1:0]     step_q;
   logic              clr_q;

   coef_t             deq  [NPT];
   coef_t             bin  [NPT];
   coef_t             bout [NPT];
   logic [PIX_W-1:0]  px   [NPT];

   for (genvar g = 0; g < NPT; g++) begin : g_lane
      localparam logic [SW-1:0] LI = SW'(g);

      // first pass: lane g reads row g of column step_q
      idct4_dequant u_dq (
         .coef_i (coef_q[{LI, step_q}]),
         .fac_i  (dqf_q[{LI, step_q}]),
         .deq_o  (deq[g])
      );

      // second pass: lane g reads column g of row step_q (transposed view)
      assign bin[g] = (ph_q == PH_ROW) ? mid_q[{step_q, LI}] : deq[g];

      idct4_px #(.PIX_W(PIX_W), .ROUND_SH(ROUND_SH)) u_px (
         .v_i    (bout[g]),
         .pred_i (pred_q[{step_q, LI}]),
         .pix_o  (px[g])
      );
   end

   idct4_bfly u_bfly (
      .x0_i (bin[0]), .x1_i (bin[1]), .x2_i (bin[2]), .x3_i (bin[3]),
      .y0_o (bout[0]), .y1_o (bout[1]), .y2_o (bout[2]), .y3_o (bout[3])
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q   <= PH_IDLE;
         step_q <= '0;
         clr_q  <= 1'b0;
         for (int i = 0; i < NEL; i++) begin
            coef_q[i] <= '0;
            dqf_q[i]  <= '0;
            pred_q[i] <= '0;
            mid_q[i]  <= '0;
            pix_q[i]  <= '0;
         end
      end else begin
         clr_q <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (in_valid) begin
                  for (int i = 0; i < NEL; i++) begin
                     coef_q[i] <= in_coef[COEF_W*i +: COEF_W];
                     dqf_q[i]  <= in_dqf[COEF_W*i +: COEF_W];
                     pred_q[i] <= in_pred[PIX_W*i +: PIX_W];
                  end
                  clr_q  <= 1'b1;
                  step_q <= '0;
                  ph_q   <= PH_COL;
               end
            end
            PH_COL: begin
               for (int k = 0; k < NPT; k++)
                  mid_q[{SW'(k), step_q}] <= bout[k];
               step_q <= step_q + 1'b1;
               if (step_q == SW'(NPT-1)) ph_q <= PH_ROW;
            end
            PH_ROW: begin
               for (int k = 0; k < NPT; k++)
                  pix_q[{step_q, SW'(k)}] <= px[k];
               step_q <= step_q + 1'b1;
               if (step_q == SW'(NPT-1)) ph_q <= PH_HOLD;
            end
            PH_HOLD: begin
               if (out_ready) ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign in_ready   = (ph_q == PH_IDLE);
   assign out_valid  = (ph_q == PH_HOLD);
   assign coef_clear = clr_q;

   for (genvar i = 0; i < NEL; i++) begin : g_out
      assign out_pix[PIX_W*i +: PIX_W] = pix_q[i];
   end
endmodule

// File: rtl/idct4_recon_chk.sv
module idct4_recon_chk #(
   parameter int unsigned PIX_W = 8
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [16*PIX_W-1:0]  out_pix,
   input logic                 coef_clear
);
   localparam int unsigned LAT = 8;

   logic [4:0] lat_q;

   always_ff @(posedge clk) begin
      if (rst)
         lat_q <= '0;
      else if (in_valid && in_ready)
         lat_q <= '0;
      else if (!out_valid && lat_q != 5'd31)
         lat_q <= lat_q + 5'd1;
   end

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

   // R7
   busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

   // R8
   clear_source_chk: assert property (@(posedge clk) disable iff (rst)
      coef_clear |-> $past(in_valid && in_ready));

   // R8
   clear_width_chk: assert property (@(posedge clk) disable iff (rst)
      coef_clear |=> !coef_clear);

   // R9
   latency_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> (lat_q == 5'(LAT)));

   // R10
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready && !coef_clear));
endmodule

bind idct4_recon idct4_recon_chk #(.PIX_W(PIX_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_pix    (out_pix),
   .coef_clear (coef_clear)
);

// File: tb/idct4_recon_tb.sv
module idct4_recon_tb;
   localparam int CW = 16;
   localparam int PW = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [16*CW-1:0] in_coef = '0;
   logic [16*CW-1:0] in_dqf  = '0;
   logic [16*PW-1:0] in_pred = '0;
   logic            out_valid;
   logic            out_ready = 1'b0;
   logic [16*PW-1:0] out_pix;
   logic            coef_clear;

   int checks = 0;
   int fails  = 0;
   logic [31:0] seed = 32'h1d2c3b4a;

   always #5 clk = ~clk;

   idct4_recon u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_coef(in_coef), .in_dqf(in_dqf), .in_pred(in_pred),
      .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
      .coef_clear(coef_clear)
   );

   typedef struct packed {
      logic [15:0] c;
      logic [15:0] q;
      logic [7:0]  p;
      logic [7:0]  e;
   } tv_t;

   // DC-only blocks: coefficient 0 = c, factor 0 = q, every predictor = p,
   // every expected pixel = e
   localparam tv_t TV [11] = '{
      '{16'd0,    16'd1,   8'd77,  8'd77},   // zero residual
      '{16'd80,   16'd1,   8'd100, 8'd110},  // R5 positive
      '{16'hFFB0, 16'd1,   8'd100, 8'd90},   // R5 -80 -> -10
      '{16'd10,   16'd8,   8'd250, 8'd255},  // R6 upper clamp
      '{16'hFF9C, 16'd16,  8'd20,  8'd0},    // R6 lower clamp
      '{16'd4,    16'd1,   8'd0,   8'd1},    // R5 4 -> 1
      '{16'd3,    16'd1,   8'd0,   8'd0},    // R5 3 -> 0
      '{16'hFFFB, 16'd1,   8'd10,  8'd9},    // R5 -5 -> -1
      '{16'hFFFC, 16'd1,   8'd10,  8'd10},   // R5 -4 -> 0
      '{16'd256,  16'd256, 8'd33,  8'd33},   // R1 product wraps to 0
      '{16'd129,  16'd256, 8'd200, 8'd0}     // R1 wraps negative
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // ---------------- reference model ----------------
   function automatic int sat16(input int v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic int ref_s(input int x);
      return (x * 35468) >>> 16;
   endfunction

   function automatic int ref_k(input int x);
      return sat16(x + ((x * 20091) >>> 16));
   endfunction

   function automatic void ref_bf(input int x0, input int x1, input int x2, input int x3,
                                  output int y0, output int y1, output int y2, output int y3);
      int e0, e1, o0, o1;
      e0 = sat16(x0 + x2);
      e1 = sat16(x0 - x2);
      o1 = sat16(ref_s(x1) - ref_k(x3));
      o0 = sat16(ref_k(x1) + ref_s(x3));
      y0 = sat16(e0 + o0);
      y1 = sat16(e1 + o1);
      y2 = sat16(e1 - o1);
      y3 = sat16(e0 - o0);
   endfunction

   function automatic logic [127:0] ref_block(input logic [255:0] c, input logic [255:0] q,
                                              input logic [127:0] p);
      int m [16];
      int t [16];
      int y [4];
      logic [127:0] r;
      for (int i = 0; i < 16; i++) begin
         logic [31:0] pr;
         logic [15:0] lo;
         pr = {16'd0, c[16*i +: 16]} * {16'd0, q[16*i +: 16]};
         lo = pr[15:0];
         m[i] = int'($signed(lo));
      end
      for (int col = 0; col < 4; col++) begin
         ref_bf(m[col], m[4+col], m[8+col], m[12+col], y[0], y[1], y[2], y[3]);
         for (int k = 0; k < 4; k++) t[4*k+col] = y[k];
      end
      for (int row = 0; row < 4; row++) begin
         ref_bf(t[4*row], t[4*row+1], t[4*row+2], t[4*row+3], y[0], y[1], y[2], y[3]);
         for (int k = 0; k < 4; k++) begin
            int v;
            v = ((y[k] + 4) >>> 3) + int'(p[8*(4*row+k) +: 8]);
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            r[8*(4*row+k) +: 8] = 8'(v);
         end
      end
      return r;
   endfunction

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // ---------------- block driver ----------------
   task automatic run_block(input logic [255:0] c, input logic [255:0] q,
                            input logic [127:0] p, output logic [127:0] got);
      int lat;
      bit rdy, clr1, clr2;
      @(negedge clk);
      in_coef  = c;
      in_dqf   = q;
      in_pred  = p;
      in_valid = 1'b1;
      rdy = in_ready;
      @(negedge clk);
      in_valid = 1'b0;
      clr1 = coef_clear;
      lat = 0;
      while (!out_valid && lat < 100) begin
         @(negedge clk);
         lat++;
         if (lat == 1) clr2 = coef_clear;
      end
      got = out_pix;
      check(rdy, "R7", "in_ready when idle", 128'(rdy), 128'd1);
      check(clr1 && !clr2, "R8", "coef_clear single pulse", {clr1, clr2}, 128'b10);
      check(lat == 8, "R9", "output latency", 128'(lat), 128'd8);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic model_test(input logic [255:0] c, input logic [255:0] q,
                             input logic [127:0] p, input string req);
      logic [127:0] got, exp;
      exp = ref_block(c, q, p);
      run_block(c, q, p, got);
      check(got === exp, req, "pixels vs model", got, exp);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(1_000_000);
      fails++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [255:0] c, q;
      logic [127:0] p, got, exp, held;

      repeat (3) @(negedge clk);
      // R10 reset state
      check(!out_valid && in_ready && !coef_clear, "R10", "reset state",
            {out_valid, in_ready, coef_clear}, 128'b010);
      rst = 1'b0;

      // table walk: R1 R5 R6
      for (int v = 0; v < 11; v++) begin
         c = '0; c[15:0] = TV[v].c;
         q = {16{16'd1}}; q[15:0] = TV[v].q;
         p = {16{TV[v].p}};
         run_block(c, q, p, got);
         check(got === {16{TV[v].e}}, "R1 R5 R6", $sformatf("table entry %0d", v),
               got, {16{TV[v].e}});
      end

      // R4 single coefficient at each raster position exposes the transpose
      for (int i = 0; i < 16; i++) begin
         c = '0; c[16*i +: 16] = 16'd300;
         model_test(c, {16{16'd1}}, {16{8'd128}}, "R4");
      end

      // R4 asymmetric: pixel 1 (row 0, col 1) vs pixel 4 (row 1, col 0)
      c = '0; c[16*1 +: 16] = 16'd200;
      run_block(c, {16{16'd1}}, {16{8'd128}}, got);
      check(got[8*1 +: 8] != got[8*4 +: 8], "R4", "row/column distinction",
            {got[8*1 +: 8], got[8*4 +: 8]}, 128'd0);

      // R2 R3 saturation: full-scale odd input drives k() and butterflies
      c = '0; c[16*1 +: 16] = 16'h7FFF;
      model_test(c, {16{16'd1}}, {16{8'd64}}, "R2 R3");
      c = '0; c[16*4 +: 16] = 16'h8001;
      model_test(c, {16{16'd1}}, {16{8'd200}}, "R2 R3");
      model_test({16{16'h7FFF}}, {16{16'd1}}, {16{8'd128}}, "R3");
      model_test({8{16'h7FFF, 16'h8001}}, {16{16'd1}}, {16{8'd128}}, "R3");

      // R2 R3 R5 random blocks, small and wide ranges
      for (int n = 0; n < 24; n++) begin
         for (int i = 0; i < 16; i++) begin
            logic [31:0] r1, r2;
            r1 = rnd(); r2 = rnd();
            if (n < 12) begin
               c[16*i +: 16] = {{8{r1[7]}}, r1[7:0]};
               q[16*i +: 16] = {10'd0, r2[5:0]};
            end else begin
               c[16*i +: 16] = r1[15:0];
               q[16*i +: 16] = r2[15:0];
            end
            p[8*i +: 8] = r1[31:24];
         end
         model_test(c, q, p, "R2 R3 R5");
      end

      // R7 stall: output held, new input ignored while busy
      c = '0; c[15:0] = 16'd160; c[16*6 +: 16] = 16'hFF00;
      q = {16{16'd3}};
      p = {16{8'd90}};
      exp = ref_block(c, q, p);
      @(negedge clk);
      in_coef = c; in_dqf = q; in_pred = p; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      while (!out_valid) @(negedge clk);
      held = out_pix;
      in_coef = '0; in_dqf = '0; in_pred = {16{8'd1}}; in_valid = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(out_valid && !in_ready && !coef_clear && out_pix === held, "R7",
               "stall hold, input ignored", {out_valid, in_ready, coef_clear}, 128'b100);
      end
      in_valid = 1'b0;
      check(out_pix === exp, "R7", "held result", out_pix, exp);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check(!out_valid && in_ready && !coef_clear, "R7", "released to idle",
            {out_valid, in_ready, coef_clear}, 128'b010);

      // R10 reset in the middle of a block
      @(negedge clk);
      in_coef = {16{16'd50}}; in_dqf = {16{16'd1}}; in_pred = '0; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!out_valid && in_ready && !coef_clear, "R10", "mid-block reset",
            {out_valid, in_ready, coef_clear}, 128'b010);
      repeat (10) @(negedge clk);
      check(!out_valid, "R10", "no output after reset", 128'(out_valid), 128'd0);
      c = '0; c[15:0] = 16'd80;
      model_test(c, {16{16'd1}}, {16{8'd100}}, "R10");

      summary();
      $finish;
   end
endmodule